// File: doc/BRIEF.md
# Quadrant Phase Resynchronizer

This block moves a word stream from a data clock into a converter clock that runs at the same frequency but at an arbitrary, slowly wandering phase. Each arriving word is written into one of four rotating slots, so every slot holds its word for four converter cycles. The converter side reads the slots back in the same rotation. Its starting point, called the quadrant, is chosen so that each slot is read well away from the moment it is overwritten.

The write position crosses into the converter domain in Gray code. It is compared every cycle with the read position. When their spacing moves by a whole slot, an alarm is raised. Three policies decide what happens next:

- Automatic: the block re-centres at once.
- Manual: the alarm is held until an update is commanded.
- External (manual plus an external select): the commanded update loads a caller-supplied quadrant instead of the computed one.

The active quadrant is always visible on a readback port, so several devices can be lined up. A pin mode also exists: it forces manual behaviour and takes updates from a pin. Looping the alarm back into that pin restores automatic recovery.

Top module: `quad_resync`

## Requirements
- R1: Once aligned, `dout` reproduces the input sequence with no gap or repeat. Sampled just after a converter edge, it equals the word taken on the data-clock edge two edges before the most recent one. The write position crosses domains changing at most one bit per data-clock edge.
- R2: A few converter cycles after reset is released, the block aligns itself with no command. After that, `alarm` stays low while the phase holds.
- R3: While reset is held, `alarm` is 0, `quad_rb` is 0 and `dout` is 0.
- R4: A slip of one whole data-clock period raises `alarm`.
- R5: In automatic mode, a raised `alarm` triggers an update on the next converter edge. The alarm is then low after exactly one cycle high. The quadrant moves by one step opposite to the slip (a lost data edge gives quadrant minus 1, modulo 4), and the stream of R1 resumes.
- R6: In manual mode (`cfg_manual`=1), a raised `alarm` stays high and `quad_rb` is unchanged until an update command arrives.
- R7: An update command (`upd_req`, one converter cycle) forces a re-alignment in every mode. With no drift, this leaves the quadrant unchanged and `alarm` low.
- R8: `quad_rb` (2 bits, modulo 4) changes only at an update, and shows the new value from the cycle after it.
- R9: When `cfg_ext`=1 and `cfg_manual`=1, an update loads `ext_quad` into `quad_rb`. A quadrant raised by d (modulo 4) above the centred value shifts `dout` by +1 for d=1, by +2 for d=2 and by -1 for d=3. When `cfg_manual`=0, `cfg_ext` is ignored.
- R10: With `host_off`=1:
  - manual mode is forced;
  - `upd_req`, `cfg_manual` and `cfg_ext` are ignored;
  - a one-cycle high on `upd_pin` is the update command;
  - driving `upd_pin` from `alarm` gives automatic recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock |
| cclk | input | 1 | Converter clock, frequency-locked to dclk |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| din | input | W | Input word, captured on dclk |
| cfg_manual | input | 1 | Manual update policy |
| cfg_ext | input | 1 | External quadrant policy (needs cfg_manual) |
| ext_quad | input | 2 | Quadrant loaded in external policy |
| upd_req | input | 1 | Update command pulse (register path) |
| host_off | input | 1 | Pin mode: forced manual, updates from upd_pin |
| upd_pin | input | 1 | Update command in pin mode |
| dout | output | W | Re-timed word, converter domain |
| alarm | output | 1 | Phase drift alarm |
| quad_rb | output | 2 | Active quadrant readback |

## Verification
The bench drops single data-clock edges to create whole-slot slips. Four slips in a row walk the computed quadrant through all four values, catching a design that re-centres in the wrong direction or misses a wrap. Every external quadrant is then forced, and the exact output word offset is checked for each. An off-by-one in read pointer arithmetic would show up there as a constant word shift or as torn data.

Manual holding and pin-mode suppression of the register command are checked at the ports. A design that updated early, or that accepted `upd_req` in pin mode, would move `quad_rb` or drop `alarm` before the pin pulse arrives.

// File: rtl/qsync_pkg.sv
package qsync_pkg;

    localparam int QW    = 2;
    localparam int NSLOT = 1 << QW;

    typedef logic [QW-1:0] qidx_t;

    typedef struct packed {
        logic manual;
        logic ext;
        logic upd;
    } policy_t;

    function automatic qidx_t bin2gray(qidx_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic qidx_t gray2bin(qidx_t g);
        qidx_t b;
        b[QW-1] = g[QW-1];
        for (int i = QW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // pin mode forces manual, drops the register-side controls
    function automatic policy_t resolve_policy(logic host_off, logic cfg_manual,
                                               logic cfg_ext, logic upd_req,
                                               logic upd_pin);
        policy_t p;
        p.manual = host_off | cfg_manual;
        p.ext    = ~host_off & cfg_manual & cfg_ext;
        p.upd    = host_off ? upd_pin : upd_req;
        return p;
    endfunction

endpackage

// File: rtl/qsync_wr_bank.sv
module qsync_wr_bank
    import qsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                      dclk,
    input  logic                      rst,
    input  logic [W-1:0]              din,
    output logic [NSLOT-1:0][W-1:0]   slots,
    output qidx_t                     wgray
);

    qidx_t wptr;

    always_ff @(posedge dclk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
            slots <= '0;
        end else begin
            slots[wptr] <= din;
            wptr        <= wptr + 1'b1;
            wgray       <= bin2gray(wptr + 1'b1);
        end
    end

    // crossing value must never change by more than one bit per edge
    assert_gray_step_R1: assert property (@(posedge dclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/qsync_gray_sync.sv
module qsync_gray_sync
    import qsync_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  cclk,
    input  logic  rst,
    input  qidx_t gin,
    output qidx_t bout
);

    qidx_t pipe [STAGES];

    always_ff @(posedge cclk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= gin;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge cclk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign bout = gray2bin(pipe[STAGES-1]);

endmodule

// File: rtl/qsync_rd_ctrl.sv
module qsync_rd_ctrl
    import qsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    cclk,
    input  logic    rst,
    input  qidx_t   wsync,
    input  policy_t pol,
    input  qidx_t   ext_quad,
    output qidx_t   rptr,
    output qidx_t   quad,
    output logic    alarm
);

    localparam int    INIT_CYC = SYNC_STAGES + 2;
    localparam int    ICW      = $clog2(INIT_CYC + 1);
    localparam qidx_t NOM      = qidx_t'(1);

    qidx_t          cnt;
    qidx_t          quad_q;
    logic           alarm_q;
    logic           live;
    logic [ICW-1:0] init_cnt;

    qidx_t margin;
    qidx_t new_quad;
    logic  drift;
    logic  init_fire;
    logic  fire;

    assign rptr      = cnt + quad_q;
    assign margin    = wsync - rptr;
    assign drift     = live && (margin != NOM);
    assign init_fire = !live && (init_cnt == ICW'(INIT_CYC - 1));
    assign fire      = init_fire | pol.upd | (!pol.manual & alarm_q);
    assign new_quad  = pol.ext ? ext_quad : qidx_t'(wsync - cnt - NOM);

    always_ff @(posedge cclk) begin
        if (rst) begin
            cnt      <= '0;
            quad_q   <= '0;
            alarm_q  <= 1'b0;
            live     <= 1'b0;
            init_cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (!live) init_cnt <= init_cnt + 1'b1;
            if (init_fire) live <= 1'b1;
            if (fire) quad_q <= new_quad;
            if (fire)       alarm_q <= 1'b0;
            else if (drift) alarm_q <= 1'b1;
        end
    end

    assign quad  = quad_q;
    assign alarm = alarm_q;

    // R5: automatic policy answers an alarm on the next edge
    assert_auto_clear_R5: assert property (@(posedge cclk) disable iff (rst)
        (alarm_q && !pol.manual) |=> !alarm_q);

    // R6: manual policy holds the alarm until a command
    assert_manual_hold_R6: assert property (@(posedge cclk) disable iff (rst)
        (alarm_q && pol.manual && !pol.upd) |=> alarm_q);

    // R8: quadrant moves only on an update
    assert_quad_stable_R8: assert property (@(posedge cclk) disable iff (rst)
        (live && !pol.upd && (pol.manual || !alarm_q)) |=> $stable(quad_q));

    // R9: external policy loads the supplied quadrant
    assert_ext_load_R9: assert property (@(posedge cclk) disable iff (rst)
        (pol.upd && pol.ext) |=> (quad_q == $past(ext_quad)));

endmodule

// File: rtl/quad_resync.sv
module quad_resync
    import qsync_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         dclk,
    input  logic         cclk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         cfg_manual,
    input  logic         cfg_ext,
    input  logic [1:0]   ext_quad,
    input  logic         upd_req,
    input  logic         host_off,
    input  logic         upd_pin,
    output logic [W-1:0] dout,
    output logic         alarm,
    output logic [1:0]   quad_rb
);

    logic [NSLOT-1:0][W-1:0] slots;
    qidx_t   wgray;
    qidx_t   wsync;
    qidx_t   rptr;
    qidx_t   quad;
    policy_t pol;

    assign pol = resolve_policy(host_off, cfg_manual, cfg_ext, upd_req, upd_pin);

    qsync_wr_bank #(.W(W)) u_wr (
        .dclk  (dclk),
        .rst   (rst),
        .din   (din),
        .slots (slots),
        .wgray (wgray)
    );

    qsync_gray_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .cclk (cclk),
        .rst  (rst),
        .gin  (wgray),
        .bout (wsync)
    );

    qsync_rd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rd (
        .cclk     (cclk),
        .rst      (rst),
        .wsync    (wsync),
        .pol      (pol),
        .ext_quad (qidx_t'(ext_quad)),
        .rptr     (rptr),
        .quad     (quad),
        .alarm    (alarm)
    );

    always_ff @(posedge cclk) begin
        if (rst) dout <= '0;
        else     dout <= slots[rptr];
    end

    assign quad_rb = quad;

    // R10: in pin mode the register command alone never moves the quadrant
    assert_pin_mode_R10: assert property (@(posedge cclk) disable iff (rst)
        (host_off && upd_req && !upd_pin && alarm) |=> $stable(quad_rb));

endmodule

// File: tb/sim_quad_resync.sv
module sim_quad_resync;

    localparam int CLK_P = 10;
    localparam int W     = 8;

    logic         dclk = 1'b0;
    logic         cclk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         cfg_manual = 1'b0;
    logic         cfg_ext = 1'b0;
    logic [1:0]   ext_quad = '0;
    logic         upd_req = 1'b0;
    logic         host_off = 1'b0;
    logic         pin_drive = 1'b0;
    logic         tie = 1'b0;
    logic         upd_pin;
    logic [W-1:0] dout;
    logic         alarm;
    logic [1:0]   quad_rb;

    int vectors = 0;
    int miscomp = 0;
    int skips_req = 0;
    int skips_done = 0;
    bit finished = 0;
    logic [W-1:0] latest = '0;
    int qc = 0;

    assign upd_pin = tie ? alarm : pin_drive;

    quad_resync #(.W(W)) u0 (
        .dclk(dclk), .cclk(cclk), .rst(rst), .din(din),
        .cfg_manual(cfg_manual), .cfg_ext(cfg_ext), .ext_quad(ext_quad),
        .upd_req(upd_req), .host_off(host_off), .upd_pin(upd_pin),
        .dout(dout), .alarm(alarm), .quad_rb(quad_rb)
    );

    always #(CLK_P/2) cclk = ~cclk;

    // data clock: half a period behind, can drop a single edge on request
    initial begin
        #(CLK_P);
        forever begin
            if (skips_done != skips_req) begin
                skips_done++;
                #(CLK_P);
            end else begin
                dclk = 1'b1;
                #(CLK_P/2);
                dclk = 1'b0;
                #(CLK_P/2);
            end
        end
    end

    always @(negedge dclk) din <= din + 1'b1;
    always @(posedge dclk) latest = din;

    task automatic step(input int n);
        repeat (n) @(posedge cclk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int off);
        return (int'(latest) - 2 + off) & ((1 << W) - 1);
    endfunction

    task automatic pulse_upd();
        upd_req = 1'b1;
        step(1);
        upd_req = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        step(6);
        // R3 reset state
        check("R3 alarm", int'(alarm), 0);
        check("R3 quad", int'(quad_rb), 0);
        check("R3 dout", int'(dout), 0);

        rst = 1'b0;
        step(12);
        // R2 self alignment, R1 in-order stream at fixed offset
        check("R2 alarm after start", int'(alarm), 0);
        for (int i = 0; i < 8; i++) begin
            check("R1 stream", int'(dout), exp_word(0));
            step(1);
        end
        qc = int'(quad_rb);

        // R7 forced update with no drift
        pulse_upd();
        step(3);
        check("R7 quad kept", int'(quad_rb), qc);
        check("R7 alarm", int'(alarm), 0);
        check("R7 stream", int'(dout), exp_word(0));

        // R4 R5 automatic recovery, walking all quadrants
        for (int k = 0; k < 4; k++) begin
            int highs;
            highs = 0;
            skips_req++;
            for (int c = 0; c < 12; c++) begin
                step(1);
                if (alarm) highs++;
            end
            check("R4 R5 alarm one cycle", highs, 1);
            qc = (qc - 1) & 3;
            check("R5 quad step", int'(quad_rb), qc);
            check("R5 stream", int'(dout), exp_word(0));
        end

        // R6 manual hold
        cfg_manual = 1'b1;
        skips_req++;
        step(8);
        check("R4 R6 alarm raised", int'(alarm), 1);
        check("R6 quad held", int'(quad_rb), qc);
        step(5);
        check("R6 alarm held", int'(alarm), 1);
        pulse_upd();
        step(2);
        check("R6 alarm cleared", int'(alarm), 0);
        qc = (qc - 1) & 3;
        check("R8 quad refreshed", int'(quad_rb), qc);
        check("R6 stream", int'(dout), exp_word(0));

        // R9 every external quadrant
        cfg_ext = 1'b1;
        for (int q = 0; q < 4; q++) begin
            int d;
            int off;
            ext_quad = 2'(q);
            pulse_upd();
            step(4);
            d   = (q - qc) & 3;
            off = (d == 3) ? -1 : d;
            check("R9 quad loaded", int'(quad_rb), q);
            check("R9 stream offset", int'(dout), exp_word(off));
            check("R9 alarm", int'(alarm), (q != qc) ? 1 : 0);
        end

        // R9 external select ignored without manual
        cfg_manual = 1'b0;
        ext_quad = 2'((qc + 2) & 3);
        step(3);
        pulse_upd();
        step(3);
        check("R9 ext ignored", int'(quad_rb), qc);
        check("R9 stream restored", int'(dout), exp_word(0));
        cfg_ext = 1'b0;

        // R10 pin mode: forced manual, register command ignored
        host_off = 1'b1;
        skips_req++;
        step(8);
        check("R10 forced manual alarm", int'(alarm), 1);
        pulse_upd();
        step(3);
        check("R10 upd_req ignored alarm", int'(alarm), 1);
        check("R10 upd_req ignored quad", int'(quad_rb), qc);
        pin_drive = 1'b1;
        step(1);
        pin_drive = 1'b0;
        step(2);
        qc = (qc - 1) & 3;
        check("R10 pin update alarm", int'(alarm), 0);
        check("R10 pin update quad", int'(quad_rb), qc);

        // R10 alarm looped to pin gives automatic recovery
        tie = 1'b1;
        skips_req++;
        step(12);
        qc = (qc - 1) & 3;
        check("R10 loop alarm", int'(alarm), 0);
        check("R10 loop quad", int'(quad_rb), qc);
        check("R10 loop stream", int'(dout), exp_word(0));

        finished = 1;
        summary();
        $finish;
    end

endmodule